// File: doc/BRIEF.md
# Mailbox Request Sequencer

This engine runs the requester side of a 256-bit shared mailbox that sets up or tears down a control channel. A single start pulse, with an opcode, launches the command. The opcode selects create or destroy. The engine samples four queue base addresses, an interrupt vector number and a reset-function flag at the same moment. It waits until the requester owns the mailbox, lays out the message and writes it so that the header word goes last. The final write hands the mailbox to the responder. The engine then polls for ownership to come back and judges the response header.

The aperture holds eight 32-bit words and is reached through a simple register master port. A request stays raised until the slave acknowledges it. A read completes with data on the acknowledge cycle. When the command ends, the engine gives a one-cycle done pulse and a result code: 0 none, 1 timeout, 2 invalid argument, 3 protocol mismatch, 4 operation failed. The code stays unchanged until the next accepted start.

Top module: `mbox_req_seq`

## Requirements
- R1: After reset, busy, done and reg_req are low and err_code is 0. While the engine is idle, reg_req stays low.
- R2: Before it issues a command, the engine reads word index 7 until a read returns bit 31 clear. After each read with bit 31 set, reg_req stays low for at least poll_gap cycles before the next read. Every poll read targets index 7.
- R3: If POLL_LIMIT consecutive poll reads in one poll phase all return bit 31 set, the command ends with code 1. When this happens before the command is issued, no write occurs.
- R4: A create command is rejected with code 2, after ownership is gained and before any write, in two cases: any queue address has a nonzero value in its low PAGE_SHIFT bits, or the vector has any bit set at position 16 or above. A destroy command skips this check.
- R5: Create writes word indices 0 through 7 in ascending order. Word i is message bits [32i+31:32i]. Message bits [48q+47:48q] hold frame-number bits [47:0] of queue q, where frame number = address >> PAGE_SHIFT, and q is 0 event, 1 completion, 2 receive, 3 send. Bits [192+4q+3:192+4q] hold frame-number bits [51:48] of queue q. Bits [223:208] hold the vector. Bits [255:224] hold the header.
- R6: The header word carries the type in bits [2:0] (1 create, 2 destroy) and the reset flag in bit 24. All other bits are zero: version bits [5:3], direction bit 7 and status bits [15:8].
- R7: Destroy performs exactly one write, the header, at index 7.
- R8: After the header write, the engine polls index 7 again using the R2 and R3 rules. If the reset flag is set, a read of 0xFFFFFFFF ends the command with code 0 and no further checks. If the reset flag is clear, that value counts as busy.
- R9: The response is accepted only when bits [2:0] equal the request type, bits [5:3] are not greater than the requested version 0, and bit 7 is 1. Any other response gives code 3.
- R10: An accepted response with a nonzero status in bits [15:8] gives code 4. Otherwise the code is 0.
- R11: done pulses for one cycle at the end of a command, and busy is low in that cycle. err_code takes its new value with done and holds it until the next accepted start.
- R12: A start pulse that arrives while busy is high is ignored. The running command completes with the inputs it sampled, and it gives exactly one done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Command launch pulse |
| op_destroy | input | 1 | 1 = destroy command, 0 = create command |
| reset_fn | input | 1 | Reset-function flag copied into the header |
| evq_addr | input | ADDR_W | Event queue base address |
| cmq_addr | input | ADDR_W | Completion queue base address |
| rxq_addr | input | ADDR_W | Receive queue base address |
| txq_addr | input | ADDR_W | Send queue base address |
| irq_vec | input | VEC_W | Interrupt vector number |
| poll_gap | input | GAP_W | Idle cycles between busy poll reads |
| reg_req | output | 1 | Register access request, held until reg_ack |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_idx | output | 3 | Aperture word index |
| reg_wdata | output | 32 | Write data |
| reg_ack | input | 1 | Access acknowledge |
| reg_rdata | input | 32 | Read data, valid with reg_ack |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 3 | Result code of the last command |

## Verification
The hardest situations to reach are the ones where the response phase times out or where a reset-state pattern reads back. In both, the engine must already have handed the mailbox over. The bench builds a mailbox model that counts reads of word 7. It answers busy for a programmed number of reads before the handoff and after the handoff, then returns a chosen response word. With that model, a single command can reach a timeout after a successful write, or read 0xFFFFFFFF with the reset flag set and with it clear. The same model measures the idle time of the request line after each busy answer, so that a missing poll gap shows up.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  localparam int WORD_W  = 32;
  localparam int N_WORDS = 8;
  localparam int MSG_W   = WORD_W * N_WORDS;
  localparam int IDX_W   = $clog2(N_WORDS);
  localparam logic [IDX_W-1:0] HDR_IDX = IDX_W'(N_WORDS - 1);

  localparam int LO_W  = 48;
  localparam int HI_W  = 4;
  localparam int FRN_W = LO_W + HI_W;
  localparam int NIB_BASE = 4 * LO_W;
  localparam int VEC_BASE = NIB_BASE + 4 * HI_W;

  localparam logic [2:0] KIND_CREATE  = 3'd1;
  localparam logic [2:0] KIND_DESTROY = 3'd2;
  localparam logic [2:0] REQ_VER      = 3'd0;

  localparam logic [2:0] RC_NONE    = 3'd0;
  localparam logic [2:0] RC_TIMEOUT = 3'd1;
  localparam logic [2:0] RC_BADARG  = 3'd2;
  localparam logic [2:0] RC_PROTO   = 3'd3;
  localparam logic [2:0] RC_OPFAIL  = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_POLL_RD, ST_POLL_GAP, ST_ARGS, ST_WRITE
  } seq_st_e;

  function automatic logic [WORD_W-1:0] make_hdr(input logic [2:0] kind, input logic rst_flag);
    logic [WORD_W-1:0] h;
    h        = '0;
    h[2:0]   = kind;
    h[5:3]   = REQ_VER;
    h[7]     = 1'b0;
    h[24]    = rst_flag;
    return h;
  endfunction

  function automatic logic [2:0] judge_rsp(input logic [WORD_W-1:0] r, input logic [2:0] kind);
    if (r[2:0] != kind || r[5:3] > REQ_VER || !r[7]) return RC_PROTO;
    if (r[15:8] != 8'h00) return RC_OPFAIL;
    return RC_NONE;
  endfunction

endpackage

// File: rtl/mbox_msg_pack.sv
module mbox_msg_pack
  import mbox_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int PAGE_SHIFT = 12,
  parameter int VEC_W      = 32
) (
  input  logic [3:0][ADDR_W-1:0] q_addr,
  input  logic [VEC_W-1:0]       vec,
  input  logic [2:0]             kind,
  input  logic                   rst_flag,
  output logic [MSG_W-1:0]       msg,
  output logic                   args_ok
);
  logic [3:0]       aligned;
  logic [LO_W-1:0]  frn_lo [4];
  logic [HI_W-1:0]  frn_hi [4];
  logic [15:0]      vec16;
  logic             vec_ok;

  for (genvar q = 0; q < 4; q++) begin : g_queue
    logic [ADDR_W-1:0] frn;
    assign frn        = q_addr[q] >> PAGE_SHIFT;
    assign aligned[q] = (q_addr[q][PAGE_SHIFT-1:0] == '0);
    assign frn_lo[q]  = frn[LO_W-1:0];
    assign frn_hi[q]  = frn[FRN_W-1:LO_W];
  end

  if (VEC_W > 16) begin : g_vec_wide
    assign vec_ok = (vec[VEC_W-1:16] == '0);
    assign vec16  = vec[15:0];
  end else begin : g_vec_narrow
    assign vec_ok = 1'b1;
    assign vec16  = 16'(vec);
  end

  assign args_ok = (&aligned) && vec_ok;

  always_comb begin
    msg = '0;
    for (int q = 0; q < 4; q++) begin
      msg[q*LO_W +: LO_W]            = frn_lo[q];
      msg[NIB_BASE + q*HI_W +: HI_W] = frn_hi[q];
    end
    msg[VEC_BASE +: 16]                 = vec16;
    msg[HDR_IDX*WORD_W +: WORD_W]       = make_hdr(kind, rst_flag);
  end

endmodule

// File: rtl/mbox_poll_timer.sv
module mbox_poll_timer #(
  parameter int LIMIT = 20000,
  parameter int GAP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             miss,
  input  logic [GAP_W-1:0] gap_len,
  output logic             last_try,
  output logic             gap_zero
);
  localparam int CNT_W = $clog2(LIMIT + 1);

  logic [CNT_W-1:0] att_cnt;
  logic [GAP_W-1:0] gap_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      att_cnt <= '0;
      gap_cnt <= '0;
    end else begin
      if (clr) att_cnt <= '0;
      else if (miss && !last_try) att_cnt <= att_cnt + 1'b1;
      if (miss) gap_cnt <= gap_len;
      else if (!gap_zero) gap_cnt <= gap_cnt - 1'b1;
    end
  end

  assign last_try = (att_cnt == CNT_W'(LIMIT - 1));
  assign gap_zero = (gap_cnt == '0);

  p_att_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    att_cnt < CNT_W'(LIMIT));

endmodule

// File: rtl/mbox_req_seq.sv
module mbox_req_seq
  import mbox_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int PAGE_SHIFT = 12,
  parameter int VEC_W      = 32,
  parameter int GAP_W      = 16,
  parameter int POLL_LIMIT = 20000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_destroy,
  input  logic              reset_fn,
  input  logic [ADDR_W-1:0] evq_addr,
  input  logic [ADDR_W-1:0] cmq_addr,
  input  logic [ADDR_W-1:0] rxq_addr,
  input  logic [ADDR_W-1:0] txq_addr,
  input  logic [VEC_W-1:0]  irq_vec,
  input  logic [GAP_W-1:0]  poll_gap,
  output logic              reg_req,
  output logic              reg_we,
  output logic [2:0]        reg_idx,
  output logic [31:0]       reg_wdata,
  input  logic              reg_ack,
  input  logic [31:0]       reg_rdata,
  output logic              busy,
  output logic              done,
  output logic [2:0]        err_code
);
  seq_st_e                 state;
  logic [IDX_W-1:0]        idx_q;
  logic                    rsp_phase;
  logic                    destroy_q;
  logic                    rst_q;
  logic [3:0][ADDR_W-1:0]  addr_q;
  logic [VEC_W-1:0]        vec_q;
  logic [MSG_W-1:0]        msg;
  logic                    args_ok;
  logic [2:0]              kind;
  logic                    last_try;
  logic                    gap_zero;
  logic                    fin;
  logic [2:0]              fin_code;

  // named internal events
  logic accept, rd_fire, wr_fire, rd_reset_ok, rd_owned, rd_miss, tmr_clr;
  assign accept      = (state == ST_IDLE) && start;
  assign rd_fire     = (state == ST_POLL_RD) && reg_ack;
  assign wr_fire     = (state == ST_WRITE) && reg_ack;
  assign rd_reset_ok = rd_fire && rsp_phase && rst_q && (reg_rdata == '1);
  assign rd_owned    = rd_fire && !reg_rdata[31];
  assign rd_miss     = rd_fire && reg_rdata[31] && !rd_reset_ok;
  assign tmr_clr     = accept || (wr_fire && idx_q == HDR_IDX);

  assign kind = destroy_q ? KIND_DESTROY : KIND_CREATE;

  mbox_msg_pack #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .VEC_W(VEC_W)) u_pack (
    .q_addr  (addr_q),
    .vec     (vec_q),
    .kind    (kind),
    .rst_flag(rst_q),
    .msg     (msg),
    .args_ok (args_ok)
  );

  mbox_poll_timer #(.LIMIT(POLL_LIMIT), .GAP_W(GAP_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (tmr_clr),
    .miss    (rd_miss),
    .gap_len (poll_gap),
    .last_try(last_try),
    .gap_zero(gap_zero)
  );

  always_comb begin
    fin      = 1'b0;
    fin_code = RC_NONE;
    if (rd_reset_ok) begin
      fin = 1'b1;
    end else if (rd_owned && rsp_phase) begin
      fin      = 1'b1;
      fin_code = judge_rsp(reg_rdata, kind);
    end else if (rd_miss && last_try) begin
      fin      = 1'b1;
      fin_code = RC_TIMEOUT;
    end else if (state == ST_ARGS && !args_ok) begin
      fin      = 1'b1;
      fin_code = RC_BADARG;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      idx_q     <= '0;
      rsp_phase <= 1'b0;
      destroy_q <= 1'b0;
      rst_q     <= 1'b0;
      addr_q    <= '0;
      vec_q     <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      err_code  <= RC_NONE;
    end else begin
      done <= 1'b0;
      if (fin) begin
        state    <= ST_IDLE;
        busy     <= 1'b0;
        done     <= 1'b1;
        err_code <= fin_code;
      end else begin
        unique case (state)
          ST_IDLE: if (start) begin
            destroy_q <= op_destroy;
            rst_q     <= reset_fn;
            addr_q    <= {txq_addr, rxq_addr, cmq_addr, evq_addr};
            vec_q     <= irq_vec;
            busy      <= 1'b1;
            err_code  <= RC_NONE;
            rsp_phase <= 1'b0;
            state     <= ST_POLL_RD;
          end
          ST_POLL_RD: begin
            if (rd_owned) begin
              state <= destroy_q ? ST_WRITE : ST_ARGS;
              idx_q <= destroy_q ? HDR_IDX : '0;
            end else if (rd_miss) begin
              state <= ST_POLL_GAP;
            end
          end
          ST_POLL_GAP: if (gap_zero) state <= ST_POLL_RD;
          ST_ARGS: begin
            state <= ST_WRITE;
            idx_q <= '0;
          end
          ST_WRITE: if (wr_fire) begin
            if (idx_q == HDR_IDX) begin
              state     <= ST_POLL_RD;
              rsp_phase <= 1'b1;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign reg_req   = (state == ST_POLL_RD) || (state == ST_WRITE);
  assign reg_we    = (state == ST_WRITE);
  assign reg_idx   = (state == ST_WRITE) ? idx_q : HDR_IDX;
  assign reg_wdata = msg[idx_q*WORD_W +: WORD_W];

  p_req_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !reg_req);

  p_poll_hdr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_we) |-> (reg_idx == HDR_IDX));

  p_write_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && reg_idx != HDR_IDX) |=> (reg_req && reg_we && reg_idx == $past(reg_idx) + 3'd1));

  p_destroy_hdr_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && destroy_q) |-> (reg_idx == HDR_IDX));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_err_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(err_code));

  p_busy_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !fin) |=> busy);

endmodule

// File: tb/test_mbox_req_seq.sv
module test_mbox_req_seq;
  localparam int LIMIT = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        op_destroy = 1'b0;
  logic        reset_fn = 1'b0;
  logic [63:0] evq_addr = '0, cmq_addr = '0, rxq_addr = '0, txq_addr = '0;
  logic [31:0] irq_vec = '0;
  logic [15:0] poll_gap = '0;
  logic        reg_req, reg_we;
  logic [2:0]  reg_idx;
  logic [31:0] reg_wdata;
  logic        reg_ack = 1'b0;
  logic [31:0] reg_rdata = '0;
  logic        busy, done;
  logic [2:0]  err_code;

  always #2 clk = ~clk;

  mbox_req_seq #(.POLL_LIMIT(LIMIT)) i_mbox_req_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op_destroy(op_destroy), .reset_fn(reset_fn),
    .evq_addr(evq_addr), .cmq_addr(cmq_addr), .rxq_addr(rxq_addr), .txq_addr(txq_addr),
    .irq_vec(irq_vec), .poll_gap(poll_gap),
    .reg_req(reg_req), .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .reg_ack(reg_ack), .reg_rdata(reg_rdata),
    .busy(busy), .done(done), .err_code(err_code)
  );

  int total = 0;
  int bad = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // mailbox model and write scoreboard
  logic [34:0] exp_q[$];
  int          pre_left, rsp_left, rd_seen, idle_run, done_cnt;
  logic [31:0] rsp_word;
  logic [15:0] gap_now;
  bit          written7, last_busy, gap_bad;

  always @(negedge clk) if (done) done_cnt++;

  always @(posedge clk) begin
    logic [31:0] v;
    logic [34:0] e;
    if (rst_n && reg_req && !reg_ack) begin
      reg_ack <= 1'b1;
      if (reg_we) begin
        if (exp_q.size() == 0) begin
          check("R5 unexpected write idx", {29'd0, reg_idx}, 32'hFFFF_FFFF);
        end else begin
          e = exp_q.pop_front();
          check("R5 write index", {29'd0, reg_idx}, {29'd0, e[34:32]});
          check("R5 write data", reg_wdata, e[31:0]);
        end
        if (reg_idx == 3'd7) written7 = 1;
      end else begin
        rd_seen++;
        if (reg_idx != 3'd7) check("R2 poll index", {29'd0, reg_idx}, 32'd7);
        if (last_busy && idle_run < int'(gap_now)) gap_bad = 1;
        if (!written7) begin
          if (pre_left > 0) begin pre_left--; v = 32'h8000_0000; end
          else v = 32'h0;
        end else if (rsp_left > 0) begin
          rsp_left--; v = 32'h8000_0000;
        end else v = rsp_word;
        reg_rdata <= v;
        last_busy = v[31];
      end
      idle_run = 0;
    end else begin
      reg_ack <= 1'b0;
      if (!reg_req) idle_run++;
    end
  end

  function automatic logic [255:0] build_msg(input logic dstr, input logic rflag,
      input logic [63:0] a0, input logic [63:0] a1, input logic [63:0] a2, input logic [63:0] a3,
      input logic [31:0] vec);
    logic [7:0]  by [32];
    logic [63:0] a [4];
    logic [63:0] pfn;
    logic [15:0] nib;
    logic [31:0] hdr;
    logic [255:0] m;
    a[0] = a0; a[1] = a1; a[2] = a2; a[3] = a3;
    nib = '0;
    for (int q = 0; q < 4; q++) begin
      pfn = a[q] >> 12;
      for (int b = 0; b < 6; b++) by[q*6 + b] = pfn[b*8 +: 8];
      nib = nib | (16'(pfn[51:48]) << (q*4));
    end
    by[24] = nib[7:0];  by[25] = nib[15:8];
    by[26] = vec[7:0];  by[27] = vec[15:8];
    hdr = (dstr ? 32'd2 : 32'd1) | (32'(rflag) << 24);
    for (int b = 0; b < 4; b++) by[28 + b] = hdr[b*8 +: 8];
    for (int i = 0; i < 32; i++) m[i*8 +: 8] = by[i];
    return m;
  endfunction

  task automatic launch(input logic dstr, input logic rflag,
      input logic [63:0] a0, input logic [63:0] a1, input logic [63:0] a2, input logic [63:0] a3,
      input logic [31:0] vec, input logic [15:0] gap, input int pre, input int rbusy,
      input logic [31:0] rword);
    logic [255:0] m;
    bit ok;
    @(negedge clk);
    pre_left = pre; rsp_left = rbusy; rsp_word = rword; written7 = 0;
    rd_seen = 0; gap_bad = 0; gap_now = gap; last_busy = 0;
    ok = (((a0 | a1 | a2 | a3) & 64'hFFF) == 0) && (vec[31:16] == 0);
    m = build_msg(dstr, rflag, a0, a1, a2, a3, vec);
    if (pre < LIMIT) begin
      if (dstr) exp_q.push_back({3'd7, m[255:224]});
      else if (ok) for (int i = 0; i < 8; i++) exp_q.push_back({3'(i), m[i*32 +: 32]});
    end
    op_destroy = dstr; reset_fn = rflag;
    evq_addr = a0; cmq_addr = a1; rxq_addr = a2; txq_addr = a3;
    irq_vec = vec; poll_gap = gap;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string tag, output logic [2:0] e);
    bit seen = 0;
    for (int n = 0; n < 5000; n++) begin
      if (done) begin seen = 1; break; end
      @(negedge clk);
    end
    check({tag, " R11 done seen"}, 32'(seen), 32'd1);
    check({tag, " R11 busy low at done"}, 32'(busy), 32'd0);
    e = err_code;
  endtask

  task automatic run(input string tag, input logic dstr, input logic rflag,
      input logic [63:0] a0, input logic [63:0] a1, input logic [63:0] a2, input logic [63:0] a3,
      input logic [31:0] vec, input logic [15:0] gap, input int pre, input int rbusy,
      input logic [31:0] rword, input logic [2:0] exp_err, input int exp_reads);
    logic [2:0] e;
    launch(dstr, rflag, a0, a1, a2, a3, vec, gap, pre, rbusy, rword);
    wait_done(tag, e);
    check({tag, " result code"}, 32'(e), 32'(exp_err));
    check({tag, " R5 all expected writes seen"}, exp_q.size(), 0);
    exp_q.delete();
    if (exp_reads >= 0) check({tag, " read count"}, rd_seen, exp_reads);
    repeat (3) @(negedge clk);
  endtask

  localparam logic [63:0] A0 = 64'h1234_5678_9ABC_D000;
  localparam logic [63:0] A1 = 64'hF000_0000_0000_1000;
  localparam logic [63:0] A2 = 64'h0000_0000_0000_0000;
  localparam logic [63:0] A3 = 64'hA5A5_A5A5_A5A5_A000;

  initial begin
    logic [2:0] e;
    int d0;
    repeat (4) @(negedge clk);
    check("R1 busy after reset", 32'(busy), 0);
    check("R1 done after reset", 32'(done), 0);
    check("R1 req after reset", 32'(reg_req), 0);
    check("R1 err after reset", 32'(err_code), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 req idle", 32'(reg_req), 0);

    // R5 R6 R2: full create with busy polls both sides
    run("R5 create", 0, 0, A0, A1, A2, A3, 32'h0000_BEEF, 16'd3, 2, 2, 32'h81, 3'd0, 6);
    check("R2 gap respected", 32'(gap_bad), 0);
    // R5 R6 with reset flag in header
    run("R6 create rst", 0, 1, A3, A2, A1, A0, 32'h0000_0001, 16'd0, 0, 0, 32'h0100_0081, 3'd0, 2);
    // R7 destroy with reset flag
    run("R7 destroy", 1, 1, A0, A1, A2, A3, 32'h0, 16'd1, 0, 1, 32'h82, 3'd0, 3);
    // R8 reset-state pattern accepted
    run("R8 reset pattern", 1, 1, A0, A1, A2, A3, 32'h0, 16'd0, 0, 0, 32'hFFFF_FFFF, 3'd0, 2);
    // R8 pattern without reset flag is busy -> timeout in response phase (R3)
    run("R8 R3 pattern no flag", 1, 0, A0, A1, A2, A3, 32'h0, 16'd2, 0, 0, 32'hFFFF_FFFF, 3'd1, 1 + LIMIT);
    // R9 protocol checks
    run("R9 wrong type", 0, 0, A0, A1, A2, A3, 32'h5, 16'd0, 0, 0, 32'h82, 3'd3, 2);
    run("R9 higher version", 0, 0, A0, A1, A2, A3, 32'h5, 16'd0, 0, 0, 32'h89, 3'd3, 2);
    run("R9 direction zero", 1, 0, A0, A1, A2, A3, 32'h0, 16'd0, 0, 0, 32'h02, 3'd3, 2);
    // R10 status failure
    run("R10 status", 0, 0, A0, A1, A2, A3, 32'h5, 16'd0, 0, 0, 32'h0581, 3'd4, 2);
    // R4 argument checks
    run("R4 misaligned", 0, 0, A0, A1 | 64'h800, A2, A3, 32'h5, 16'd0, 0, 0, 32'h81, 3'd2, 1);
    run("R4 wide vector", 0, 0, A0, A1, A2, A3, 32'h0001_0000, 16'd0, 1, 0, 32'h81, 3'd2, 2);
    run("R4 destroy skips check", 1, 0, A0 | 64'h1, A1, A2, A3, 32'hFFFF_FFFF, 16'd0, 0, 0, 32'h82, 3'd0, 2);
    // R3 ownership timeout before any write
    run("R3 pre timeout", 0, 0, A0, A1, A2, A3, 32'h5, 16'd1, 10, 0, 32'h81, 3'd1, LIMIT);
    // R11 code held
    repeat (30) @(negedge clk);
    check("R11 code held", 32'(err_code), 32'd1);
    check("R11 busy idle", 32'(busy), 0);

    // R12 start while busy ignored
    d0 = done_cnt;
    launch(0, 0, A0, A1, A2, A3, 32'h0000_1234, 16'd2, 3, 1, 32'h81);
    repeat (3) @(negedge clk);
    check("R12 busy during run", 32'(busy), 1);
    op_destroy = 1'b1; evq_addr = 64'h1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done("R12", e);
    check("R12 result code", 32'(e), 0);
    repeat (20) @(negedge clk);
    check("R12 single done", done_cnt - d0, 1);
    check("R12 all writes from first start", exp_q.size(), 0);
    check("R12 idle after", 32'(busy), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule